// File: doc/BRIEF.md
# Dual-Channel UART Host Register Decode

This block sits between a shared CPU bus and two UART channel cores. Each channel keeps its own line control byte, a two-byte baud divisor and a small alternate-function byte. A single channel-select input picks which channel a read or write reaches. Every cycle, the block hands the stored line control and divisor values to the channel cores.

The alternate-function byte has two jobs. It picks the source of each channel's multi-function output pin, and it holds one shared enable bit. When that bit is set, a single CPU write lands in the same register of both channels, so two identical channels can be set up in half the bus cycles. Offset 0 normally holds the divisor low byte. It shows a fixed identification byte instead, but only when that channel's divisor is zero and its extended-register conditions hold. Writes are taken on the rising clock edge. Read data is combinational from the bus inputs.

Top module: `duart_regif`

## Requirements
- R1: After the asynchronous active-high reset, every line control byte, divisor byte, pin-source field and the shared enable read as 0. Each multi-function output then follows that channel's OUT2 input.
- R2: Offset 3 is the line control byte of the selected channel. It is readable and writable whatever its own value.
- R3: A channel's extended view is open when its line control bit 7 is 1 and the byte is not 0xBF. With the view open, offset 1 reads and writes the divisor high byte. Offset 0 reads and writes the divisor low byte when the divisor is nonzero. A write to offset 0 always updates the divisor low byte.
- R4: With the view open and both divisor bytes at 0x00, a read of offset 0 returns 0x31 (ID nibble 0x3 in bits 7:4, revision 0x1 in bits 3:0).
- R5: With the view closed, writes to offsets 0 to 2 change nothing, and reads of those offsets return 0x00.
- R6: A line control byte of exactly 0xBF closes the view even though bit 7 is 1.
- R7: With the view open, offset 2 reads as {5'b0, pin-source[1:0], shared enable}, so bits 7:3 are always 0.
- R8: The pin-source field, bits 2:1 of offset 2, is held per channel. It drives that channel's multi-function output: 00 gives OUT2, 01 gives BAUDOUT, 10 gives RXRDY, and 11 gives a constant 1.
- R9: While the shared enable (bit 0 of offset 2) is 1, a write updates the addressed register in both channels, each channel applying its own view rule. While it is 0, only the selected channel is written.
- R10: The shared enable is one bit. A write to offset 2 through either channel sets or clears it, and both channels read back the same value.
- R11: Reads always come from the channel named by the channel select, whatever the state of the shared enable. A read in the same cycle as a write shows the value from before the write.
- R12: While the read strobe is low, the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| addr | input | 3 | Register offset |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| chSel | input | 1 | Channel select (0 or 1) |
| rxRdy | input | 2 | Receive-ready signal from each channel core |
| baudOut | input | 2 | Baud clock output from each channel core |
| out2 | input | 2 | General output 2 from each channel core |
| rdData | output | 8 | Read data for the selected channel |
| mfOut | output | 2 | Multi-function pin drive, one bit per channel |
| lcrOut | output | 16 | Line control bytes, channel 1 in the upper byte |
| divOut | output | 32 | Divisors {high, low}, channel 1 in the upper half |

## Verification
Two functions can meet in one cycle: a shared-enable write and a read. The bench sets the shared enable, then raises both strobes in the same cycle on channel 1's divisor high byte. It checks that the read shows the old value before the edge, and that both channels hold the new value afterwards. A second overlap comes from the identification view and the shared write. A concurrent write to the divisor high byte makes channel 1's divisor nonzero, so its offset 0 stops returning 0x31 and returns the zero low byte. That is judged by reading offset 0 on each channel in turn.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;
  localparam int MF_W   = 2;

  localparam logic [ADDR_W-1:0] OFS_DLL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DLM = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_AFR = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCR = 3'd3;

  localparam logic [DATA_W-1:0] ID_BYTE  = {4'h3, 4'h1};
  localparam logic [DATA_W-1:0] LCR_LOCK = 8'hBF;

  typedef enum logic [2:0] {
    RD_ZERO, RD_LCR, RD_DLL, RD_DLM, RD_AFR, RD_ID
  } rdsel_e;

  typedef enum logic [MF_W-1:0] {
    MF_OUT2  = 2'd0,
    MF_BAUD  = 2'd1,
    MF_RXRDY = 2'd2,
    MF_HIGH  = 2'd3
  } mfsel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] wrLcr;
    logic [NUM_CH-1:0] wrDll;
    logic [NUM_CH-1:0] wrDlm;
    logic [NUM_CH-1:0] wrAfr;
    rdsel_e            rdSel;
  } strobe_t;
endpackage

// File: rtl/duart_ctrl.sv
module duart_ctrl
  import duart_pkg::*;
(
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wrEn,
  input  logic                          chSel,
  input  logic                          cwEn,
  input  logic [NUM_CH-1:0][DATA_W-1:0] lcr,
  input  logic [NUM_CH-1:0]             divZero,
  output strobe_t                       stb
);
  logic [NUM_CH-1:0] extOpen;
  logic [NUM_CH-1:0] chHit;

  // Per-channel write decode; shared enable fans one write out to all channels
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign extOpen[c]   = lcr[c][DATA_W-1] && (lcr[c] != LCR_LOCK);
    assign chHit[c]     = wrEn && ((chSel == 1'(c)) || cwEn);
    assign stb.wrLcr[c] = chHit[c] && (addr == OFS_LCR);
    assign stb.wrDll[c] = chHit[c] && extOpen[c] && (addr == OFS_DLL);
    assign stb.wrDlm[c] = chHit[c] && extOpen[c] && (addr == OFS_DLM);
    assign stb.wrAfr[c] = chHit[c] && extOpen[c] && (addr == OFS_AFR);
  end

  // Read source always follows the channel select
  always_comb begin
    stb.rdSel = RD_ZERO;
    if (addr == OFS_LCR) begin
      stb.rdSel = RD_LCR;
    end else if (extOpen[chSel]) begin
      case (addr)
        OFS_DLL: stb.rdSel = divZero[chSel] ? RD_ID : RD_DLL;
        OFS_DLM: stb.rdSel = RD_DLM;
        OFS_AFR: stb.rdSel = RD_AFR;
        default: stb.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/duart_datapath.sv
module duart_datapath
  import duart_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       stb,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          rdEn,
  input  logic                          chSel,
  input  logic [NUM_CH-1:0]             rxRdy,
  input  logic [NUM_CH-1:0]             baudOut,
  input  logic [NUM_CH-1:0]             out2,
  output logic [NUM_CH-1:0][DATA_W-1:0] lcr,
  output logic [NUM_CH-1:0]             divZero,
  output logic                          cwEn,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_CH-1:0]             mfOut,
  output logic [NUM_CH-1:0][2*DATA_W-1:0] divisor
);
  localparam int PadW = DATA_W - MF_W - 1;

  logic [NUM_CH-1:0][DATA_W-1:0] dllQ;
  logic [NUM_CH-1:0][DATA_W-1:0] dlmQ;
  logic [NUM_CH-1:0][MF_W-1:0]   mfSelQ;
  logic                          cwQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        lcr[c]    <= '0;
        dllQ[c]   <= '0;
        dlmQ[c]   <= '0;
        mfSelQ[c] <= MF_OUT2;
      end else begin
        if (stb.wrLcr[c]) lcr[c]    <= wrData;
        if (stb.wrDll[c]) dllQ[c]   <= wrData;
        if (stb.wrDlm[c]) dlmQ[c]   <= wrData;
        if (stb.wrAfr[c]) mfSelQ[c] <= wrData[MF_W:1];
      end
    end

    assign divZero[c] = (dllQ[c] == '0) && (dlmQ[c] == '0);
    assign divisor[c] = {dlmQ[c], dllQ[c]};

    always_comb begin
      case (mfsel_e'(mfSelQ[c]))
        MF_OUT2:  mfOut[c] = out2[c];
        MF_BAUD:  mfOut[c] = baudOut[c];
        MF_RXRDY: mfOut[c] = rxRdy[c];
        default:  mfOut[c] = 1'b1;
      endcase
    end
  end

  // One shared enable, written through whichever channel(s) accept the write
  always_ff @(posedge clk or posedge rst) begin
    if (rst)             cwQ <= 1'b0;
    else if (|stb.wrAfr) cwQ <= wrData[0];
  end
  assign cwEn = cwQ;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (stb.rdSel)
        RD_LCR:  rdData = lcr[chSel];
        RD_DLL:  rdData = dllQ[chSel];
        RD_DLM:  rdData = dlmQ[chSel];
        RD_AFR:  rdData = {{PadW{1'b0}}, mfSelQ[chSel], cwQ};
        RD_ID:   rdData = ID_BYTE;
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/duart_regif.sv
module duart_regif
  import duart_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic                         chSel,
  input  logic [NUM_CH-1:0]            rxRdy,
  input  logic [NUM_CH-1:0]            baudOut,
  input  logic [NUM_CH-1:0]            out2,
  output logic [DATA_W-1:0]            rdData,
  output logic [NUM_CH-1:0]            mfOut,
  output logic [NUM_CH*DATA_W-1:0]     lcrOut,
  output logic [NUM_CH*2*DATA_W-1:0]   divOut
);
  strobe_t                        stb;
  logic                           cwEn;
  logic [NUM_CH-1:0][DATA_W-1:0]  lcr;
  logic [NUM_CH-1:0]              divZero;
  logic [NUM_CH-1:0][2*DATA_W-1:0] divisor;

  duart_ctrl u_ctrl (
    .addr(addr), .wrEn(wrEn), .chSel(chSel), .cwEn(cwEn),
    .lcr(lcr), .divZero(divZero), .stb(stb)
  );

  duart_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .rdEn(rdEn),
    .chSel(chSel), .rxRdy(rxRdy), .baudOut(baudOut), .out2(out2),
    .lcr(lcr), .divZero(divZero), .cwEn(cwEn), .rdData(rdData),
    .mfOut(mfOut), .divisor(divisor)
  );

  assign lcrOut = lcr;
  assign divOut = divisor;
endmodule

// File: rtl/duart_regif_chk.sv
module duart_regif_chk
  import duart_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wrData,
  input logic                       wrEn,
  input logic                       rdEn,
  input logic                       chSel,
  input logic [DATA_W-1:0]          rdData,
  input logic [NUM_CH*DATA_W-1:0]   lcrOut,
  input logic [NUM_CH*2*DATA_W-1:0] divOut,
  input logic                       cwEn
);
  logic [DATA_W-1:0] lcr0;
  logic              view0;
  assign lcr0  = lcrOut[DATA_W-1:0];
  assign view0 = lcr0[DATA_W-1] && (lcr0 != LCR_LOCK);

  p_lcr_wr_r2: assert property (@(posedge clk) disable iff (rst)
    wrEn && addr == OFS_LCR && !chSel |=> lcrOut[DATA_W-1:0] == $past(wrData));

  p_div_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !view0 |=> $stable(divOut[2*DATA_W-1:0]));

  p_id_view_r4: assert property (@(posedge clk) disable iff (rst)
    rdEn && addr == OFS_DLL && !chSel && view0 && divOut[2*DATA_W-1:0] == '0
    |-> rdData == 8'h31);

  p_lock_rd_r6: assert property (@(posedge clk) disable iff (rst)
    rdEn && addr <= OFS_AFR && !chSel && lcr0 == 8'hBF |-> rdData == '0);

  p_afr_pad_r7: assert property (@(posedge clk) disable iff (rst)
    rdEn && addr == OFS_AFR |-> rdData[DATA_W-1:3] == '0);

  p_cw_copy_r9: assert property (@(posedge clk) disable iff (rst)
    wrEn && cwEn && addr == OFS_LCR |=> lcrOut[DATA_W-1:0] == lcrOut[2*DATA_W-1:DATA_W]);

  p_idle_rd_r12: assert property (@(posedge clk) disable iff (rst)
    !rdEn |-> rdData == '0);
endmodule

bind duart_regif duart_regif_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdEn(rdEn), .chSel(chSel), .rdData(rdData), .lcrOut(lcrOut),
  .divOut(divOut), .cwEn(cwEn)
);

// File: tb/duart_regif_bench.sv
module duart_regif_bench;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic        chSel = 1'b0;
  logic [1:0]  rxRdy = 2'b11;
  logic [1:0]  baudOut = 2'b10;
  logic [1:0]  out2 = 2'b01;
  logic [7:0]  rdData;
  logic [1:0]  mfOut;
  logic [15:0] lcrOut;
  logic [31:0] divOut;

  int testCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  duart_regif u_duart_regif (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .chSel(chSel), .rxRdy(rxRdy), .baudOut(baudOut),
    .out2(out2), .rdData(rdData), .mfOut(mfOut), .lcrOut(lcrOut),
    .divOut(divOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    chSel = ch; addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic ch, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    chSel = ch; addr = a; rdEn = 1'b1; wrEn = 1'b0;
    #1;
    check(req, 32'(rdData), 32'(exp));
    rdEn = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 lcr", 32'(lcrOut), 32'h0);
    check("R1 div", divOut, 32'h0);
    check("R1 mf=out2", 32'(mfOut), 32'(out2));
    rdChk("R1 lcr read", 1'b0, 3'd3, 8'h00);
  endtask

  task automatic t_lcr;
    wr(1'b0, 3'd3, 8'h1B);
    wr(1'b1, 3'd3, 8'h07);
    rdChk("R2 ch0", 1'b0, 3'd3, 8'h1B);
    rdChk("R2 ch1", 1'b1, 3'd3, 8'h07);
    @(negedge clk);
    chSel = 1'b0; addr = 3'd3; rdEn = 1'b0;
    #1;
    check("R12 idle read", 32'(rdData), 32'h0);
  endtask

  task automatic t_closed;
    wr(1'b0, 3'd1, 8'h55);
    wr(1'b0, 3'd2, 8'h06);
    rdChk("R5 off0", 1'b0, 3'd0, 8'h00);
    rdChk("R5 off1", 1'b0, 3'd1, 8'h00);
    rdChk("R5 off2", 1'b0, 3'd2, 8'h00);
    check("R5 div", 32'(divOut[15:0]), 32'h0);
    check("R5 mf", 32'(mfOut[0]), 32'(out2[0]));
    wr(1'b0, 3'd3, 8'h80);
    rdChk("R5 dlm kept", 1'b0, 3'd1, 8'h00);
    rdChk("R5 afr kept", 1'b0, 3'd2, 8'h00);
    wr(1'b0, 3'd3, 8'hBF);
    wr(1'b0, 3'd0, 8'h12);
    rdChk("R6 locked read", 1'b0, 3'd0, 8'h00);
    wr(1'b0, 3'd3, 8'h80);
    rdChk("R4 id ch0", 1'b0, 3'd0, 8'h31);
    wr(1'b1, 3'd3, 8'h83);
    rdChk("R4 id ch1", 1'b1, 3'd0, 8'h31);
  endtask

  task automatic t_divisor;
    wr(1'b0, 3'd0, 8'h12);
    rdChk("R3 dll", 1'b0, 3'd0, 8'h12);
    wr(1'b0, 3'd1, 8'h34);
    rdChk("R3 dlm", 1'b0, 3'd1, 8'h34);
    wr(1'b0, 3'd0, 8'h00);
    rdChk("R3 dll zero, dlm set", 1'b0, 3'd0, 8'h00);
    wr(1'b0, 3'd1, 8'h00);
    rdChk("R4 id after clear", 1'b0, 3'd0, 8'h31);
    wr(1'b0, 3'd0, 8'h05);
    rdChk("R3 write over id", 1'b0, 3'd0, 8'h05);
    check("R3 div port", 32'(divOut[15:0]), 32'h0005);
    rdChk("R4 ch1 untouched", 1'b1, 3'd0, 8'h31);
  endtask

  task automatic t_mf;
    for (int k = 0; k < 4; k++) begin
      wr(1'b0, 3'd2, 8'(k << 1));
      @(negedge clk);
      out2[0] = 1'b1; baudOut[0] = 1'b1; rxRdy[0] = 1'b1;
      if (k == 0) out2[0] = 1'b0;
      if (k == 1) baudOut[0] = 1'b0;
      if (k == 2) rxRdy[0] = 1'b0;
      if (k == 3) begin out2[0] = 1'b0; baudOut[0] = 1'b0; rxRdy[0] = 1'b0; end
      #1;
      check($sformatf("R8 ch0 code %0d", k), 32'(mfOut[0]), (k == 3) ? 32'h1 : 32'h0);
      check("R8 ch1 independent", 32'(mfOut[1]), 32'(out2[1]));
    end
    wr(1'b0, 3'd2, 8'h02);
    wr(1'b1, 3'd2, 8'h04);
    @(negedge clk);
    out2 = 2'b00; baudOut = 2'b01; rxRdy = 2'b10;
    #1;
    check("R8 per-channel", 32'(mfOut), 32'h3);
    rxRdy = 2'b00;
    #1;
    check("R8 ch1 rxrdy", 32'(mfOut), 32'h1);
    wr(1'b0, 3'd2, 8'hFE);
    rdChk("R7 afr pad", 1'b0, 3'd2, 8'h06);
  endtask

  task automatic t_concurrent;
    wr(1'b0, 3'd2, 8'h01);
    rdChk("R10 seen via ch1", 1'b1, 3'd2, 8'h05);
    rdChk("R11 ch0 dll", 1'b0, 3'd0, 8'h05);
    rdChk("R11 ch1 id", 1'b1, 3'd0, 8'h31);
    wr(1'b1, 3'd1, 8'h22);
    rdChk("R9 ch0 dlm", 1'b0, 3'd1, 8'h22);
    rdChk("R9 ch1 dlm", 1'b1, 3'd1, 8'h22);
    rdChk("R11 ch0 dll kept", 1'b0, 3'd0, 8'h05);
    rdChk("R11 ch1 dll", 1'b1, 3'd0, 8'h00);
    @(negedge clk);
    chSel = 1'b1; addr = 3'd1; wrData = 8'h44; wrEn = 1'b1; rdEn = 1'b1;
    #1;
    check("R11 read before write", 32'(rdData), 32'h22);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    rdChk("R9 same-cycle ch0", 1'b0, 3'd1, 8'h44);
    rdChk("R9 same-cycle ch1", 1'b1, 3'd1, 8'h44);
    wr(1'b1, 3'd2, 8'h00);
    rdChk("R10 cleared via ch1", 1'b0, 3'd2, 8'h00);
    wr(1'b0, 3'd3, 8'h01);
    rdChk("R9 off: ch1 lcr kept", 1'b1, 3'd3, 8'h83);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_lcr();
    t_closed();
    t_divisor();
    t_mf();
    t_concurrent();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (WatchdogCycles) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule